// File: doc/BRIEF.md
# Receive Buffer Descriptor Walker

This block places one received Ethernet frame into host memory. Host software builds a list of six-word buffer descriptors in memory and hands the list's start address to the block. When a frame is waiting, the block walks the list until it finds a usable descriptor. A descriptor can be an end marker, a jump to another descriptor or a buffer. When it finds a buffer, it copies the frame into that buffer, writes the completion status back into the descriptor and flags a receive interrupt.

The frame sits in a buffer outside the block. The block reads it byte by byte through an index output and reads its length from an input. Host memory is reached through a single request/ready port that carries word reads and writes as well as byte writes. Only one access is outstanding at a time.

After every frame, stored or not, the list is marked invalid. The block then does nothing more until software loads a fresh list address. A frame that cannot be stored is counted as a drop.

Top module: `rxdesc_dma`

## Requirements
- R1: Loading the list (`list_load` high for one cycle) takes the start address as {`list_hi[5:0]`, `list_lo[15:0]`} (22 bits) and clears the list-invalid flag. A load in the same cycle as a frame's completion wins, so the flag ends up clear.
- R2: A descriptor occupies 12 bytes at byte address P. The words read are the address-high word at P+2, the address-low word at P+4 and the length word at P+6. An address-high word with bit 15 clear ends the walk, and the frame is dropped.
- R3: An address-high word with bits 15 and 14 both set is a jump. The next descriptor is read at {addr-high[5:0], addr-low}.
- R4: For a buffer descriptor (bit 15 set, bit 14 clear), the buffer starts at {addr-high[5:0], addr-low}. Its size in bytes is twice the two's complement of the length word. The block copies min(frame length, buffer size) frame bytes into the buffer in ascending order.
- R5: The write order when a buffer is used is fixed: 0xFFFF to the word at P, then the frame bytes, then status word 1 to P+8, status word 2 to P+10, 0x0300 to P, and finally 0x0000 to P+2.
- R6: Let K be the frame length minus 60, floored at zero. Status word 1 is (K & 0x0700) | 0x00F8. Status word 2 holds K[7:0] in both its upper and its lower byte.
- R7: A stored frame sets `rx_int`. If `int_en` is high, the block also emits a one-cycle `irq_req` with `irq_vec` = `vec_reg` & 0x03FC. `rx_int_clr` clears `rx_int`, but a set in the same cycle wins.
- R8: Every completed frame sets `list_inv`. While `list_inv` is set, the block issues no memory access and leaves a waiting frame unconsumed.
- R9: A descriptor whose 12 bytes would extend past `MEM_BYTES` stops the walk without any access. Every frame that is not stored increments `drop_cnt`.
- R10: Once raised, `mem_req` stays high, with stable address, data and type, until `mem_rdy`. Read data is taken in the cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| list_hi | input | 16 | List start address, high part (bits 5:0 used) |
| list_lo | input | 16 | List start address, low part |
| list_load | input | 1 | Latch the list address and clear list-invalid |
| list_inv | output | 1 | List-invalid flag |
| int_en | input | 1 | Interrupt enable |
| vec_reg | input | 16 | Vector register value |
| rx_int_clr | input | 1 | Clear the receive interrupt flag |
| rx_int | output | 1 | Receive interrupt flag |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | 16 | Interrupt vector |
| frm_valid | input | 1 | A frame is waiting |
| frm_len | input | 11 | Frame length in bytes, stable while waiting |
| fb_idx | output | 11 | Index of the frame byte wanted |
| fb_byte | input | 8 | Frame byte at `fb_idx` |
| frm_done | output | 1 | Frame consumed, stored or dropped |
| drop_cnt | output | 16 | Count of frames not stored |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_byte | output | 1 | Write is a single byte (lane chosen by address bit 0) |
| mem_addr | output | 22 | Byte address |
| mem_wdata | output | 16 | Write data (a byte write repeats the byte in both halves) |
| mem_rdata | input | 16 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Access completes this cycle |

## Verification
Two of the block's actions can land on the same clock edge. When a frame completes, the block sets `rx_int` and `list_inv` at that edge. Software may clear `rx_int` or load a new list at exactly that moment. The bench provokes this by watching for `frm_done` and driving `rx_int_clr` and `list_load` high in that same cycle. It then expects `rx_int` to stay set and `list_inv` to end up clear. The memory model pauses `mem_rdy` in a fixed pattern, so that held requests are exercised throughout.

// File: rtl/rxdesc_dma.sv
module rxdesc_dma #(
  parameter int FLW = 11,
  parameter int DCW = 16,
  parameter int MEM_BYTES = 4194304
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    list_hi,
  input  logic [15:0]    list_lo,
  input  logic           list_load,
  output logic           list_inv,
  input  logic           int_en,
  input  logic [15:0]    vec_reg,
  input  logic           rx_int_clr,
  output logic           rx_int,
  output logic           irq_req,
  output logic [15:0]    irq_vec,
  input  logic           frm_valid,
  input  logic [FLW-1:0] frm_len,
  output logic [FLW-1:0] fb_idx,
  input  logic [7:0]     fb_byte,
  output logic           frm_done,
  output logic [DCW-1:0] drop_cnt,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_byte,
  output logic [21:0]    mem_addr,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata,
  input  logic           mem_rdy
);
  localparam int BLW = 18;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_RH, S_RL, S_RN, S_EVAL, S_WBUSY,
    S_COPY, S_WS1, S_WS2, S_WFLG, S_WPH, S_DONE
  } st_t;

  st_t state;
  logic [21:0]    base, ptr;
  logic [15:0]    ph, pl, nlen;
  logic [FLW-1:0] cnt;
  logic           stored;

  logic [BLW-1:0] blen;
  logic [FLW-1:0] ncopy, kval;
  logic [15:0]    kx, s1, s2;
  logic [21:0]    bufaddr;
  logic           fire, past_end;

  assign blen     = {({1'b0, ~nlen} + 17'd1), 1'b0};
  assign ncopy    = (BLW'(frm_len) < blen) ? frm_len : blen[FLW-1:0];
  assign kval     = (frm_len >= FLW'(60)) ? frm_len - FLW'(60) : '0;
  assign kx       = 16'(kval);
  assign s1       = (kx & 16'h0700) | 16'h00F8;
  assign s2       = {kx[7:0], kx[7:0]};
  assign bufaddr  = {ph[5:0], pl};
  assign past_end = (32'(ptr) + 32'd12) > 32'(MEM_BYTES);
  assign fire     = mem_req && mem_rdy;
  assign frm_done = (state == S_DONE);
  assign fb_idx   = cnt;

  assign mem_req  = state inside {S_RH, S_RL, S_RN, S_WBUSY, S_COPY, S_WS1, S_WS2, S_WFLG, S_WPH};
  assign mem_we   = state inside {S_WBUSY, S_COPY, S_WS1, S_WS2, S_WFLG, S_WPH};
  assign mem_byte = (state == S_COPY);

  always_comb begin
    mem_addr  = ptr;
    mem_wdata = 16'h0000;
    case (state)
      S_RH:    mem_addr = ptr + 22'd2;
      S_RL:    mem_addr = ptr + 22'd4;
      S_RN:    mem_addr = ptr + 22'd6;
      S_WBUSY: mem_wdata = 16'hFFFF;
      S_COPY:  begin mem_addr = bufaddr + 22'(cnt); mem_wdata = {fb_byte, fb_byte}; end
      S_WS1:   begin mem_addr = ptr + 22'd8;  mem_wdata = s1; end
      S_WS2:   begin mem_addr = ptr + 22'd10; mem_wdata = s2; end
      S_WFLG:  mem_wdata = 16'h0300;
      S_WPH:   mem_addr = ptr + 22'd2;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base     <= '0;
      ptr      <= '0;
      ph       <= '0;
      pl       <= '0;
      nlen     <= '0;
      cnt      <= '0;
      stored   <= 1'b0;
      list_inv <= 1'b1;
      rx_int   <= 1'b0;
      irq_req  <= 1'b0;
      irq_vec  <= '0;
      drop_cnt <= '0;
    end else begin
      irq_req <= 1'b0;
      if (list_load) base <= {list_hi[5:0], list_lo};
      if (list_load) list_inv <= 1'b0;
      else if (state == S_DONE) list_inv <= 1'b1;
      if (state == S_DONE && stored) rx_int <= 1'b1;
      else if (rx_int_clr) rx_int <= 1'b0;
      if (state == S_DONE && stored && int_en) begin
        irq_req <= 1'b1;
        irq_vec <= vec_reg & 16'h03FC;
      end
      if (state == S_DONE && !stored) drop_cnt <= drop_cnt + 1'b1;

      case (state)
        S_IDLE: if (frm_valid && !list_inv) begin ptr <= base; state <= S_CHK; end
        S_CHK:  if (past_end) begin stored <= 1'b0; state <= S_DONE; end
                else state <= S_RH;
        S_RH:   if (fire) begin ph <= mem_rdata; state <= S_RL; end
        S_RL:   if (fire) begin pl <= mem_rdata; state <= S_RN; end
        S_RN:   if (fire) begin nlen <= mem_rdata; state <= S_EVAL; end
        S_EVAL: begin
          cnt <= '0;
          if (!ph[15]) begin stored <= 1'b0; state <= S_DONE; end
          else if (ph[14]) begin ptr <= bufaddr; state <= S_CHK; end
          else state <= S_WBUSY;
        end
        S_WBUSY: if (fire) state <= (ncopy != '0) ? S_COPY : S_WS1;
        S_COPY:  if (fire) begin
          cnt <= cnt + 1'b1;
          if (cnt + 1'b1 == ncopy) state <= S_WS1;
        end
        S_WS1:  if (fire) state <= S_WS2;
        S_WS2:  if (fire) state <= S_WFLG;
        S_WFLG: if (fire) state <= S_WPH;
        S_WPH:  if (fire) begin stored <= 1'b1; state <= S_DONE; end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_idle_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && list_inv) |=> !mem_req);
  p_inv_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !list_load |=> list_inv);
  p_load_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    list_load |=> !list_inv);
  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> rx_int);
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !stored |=> drop_cnt == $past(drop_cnt) + 1'b1);
  p_copy_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_byte |-> fb_idx < frm_len);
endmodule

// File: tb/rxdesc_dma_bench.sv
module rxdesc_dma_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [15:0] list_hi = 0, list_lo = 0, vec_reg = 0, irq_vec, mem_wdata, mem_rdata;
  logic list_load = 0, list_inv, int_en = 0, rx_int_clr = 0, rx_int, irq_req;
  logic frm_valid = 0, frm_done, mem_req, mem_we, mem_byte, mem_rdy = 0;
  logic [10:0] frm_len = 0, fb_idx;
  logic [7:0] fb_byte;
  logic [15:0] drop_cnt;
  logic [21:0] mem_addr;

  logic [15:0] mem [0:2047];
  logic [7:0]  fb  [0:2047];
  logic [21:0] la [0:1023];
  logic [15:0] ld [0:1023];
  int wn = 0, acc_n = 0, irq_n = 0, cyc = 0;
  logic [15:0] last_vec = 0;
  int errors = 0, checks = 0;

  rxdesc_dma #(.MEM_BYTES(4096)) u_rxdesc_dma (.*);

  assign fb_byte   = fb[fb_idx];
  assign mem_rdata = mem[mem_addr[11:1]];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_rdy <= (cyc % 3) != 1;
  end

  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      acc_n <= acc_n + 1;
      if (mem_we) begin
        if (wn < 1024) begin la[wn] <= mem_addr; ld[wn] <= mem_wdata; end
        wn <= wn + 1;
        if (!mem_byte) mem[mem_addr[11:1]] <= mem_wdata;
        else if (mem_addr[0]) mem[mem_addr[11:1]][15:8] <= mem_wdata[7:0];
        else mem[mem_addr[11:1]][7:0] <= mem_wdata[7:0];
      end
    end
    if (irq_req) begin irq_n <= irq_n + 1; last_vec <= irq_vec; end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input int a);
    return a[0] ? mem[a >> 1][15:8] : mem[a >> 1][7:0];
  endfunction

  task automatic desc(input int p, input logic [15:0] h, input logic [15:0] l, input logic [15:0] n);
    mem[p >> 1] = 16'h1111; mem[(p >> 1) + 1] = h; mem[(p >> 1) + 2] = l;
    mem[(p >> 1) + 3] = n; mem[(p >> 1) + 4] = 16'h2222; mem[(p >> 1) + 5] = 16'h3333;
  endtask

  task automatic load_list(input int a);
    @(negedge clk);
    list_hi = 16'(a >> 16); list_lo = 16'(a); list_load = 1;
    @(negedge clk);
    list_load = 0;
  endtask

  task automatic fill_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) fb[i] = 8'(i * 7 + seed);
    frm_len = 11'(n);
  endtask

  task automatic run_frame(input bit collide);
    frm_valid = 1;
    for (int t = 0; t < 8000 && !frm_done; t++) @(negedge clk);
    if (collide) begin rx_int_clr = 1; list_load = 1; end
    frm_valid = 0;
    @(negedge clk);
    rx_int_clr = 0; list_load = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(list_inv == 1, "R8 reset list_inv", list_inv, 1);
    chk(rx_int == 0, "R7 reset rx_int", rx_int, 0);
    chk(drop_cnt == 0, "R9 reset drop_cnt", drop_cnt, 0);
    fill_frame(20, 1);
    frm_valid = 1;
    repeat (20) @(negedge clk);
    chk(acc_n == 0, "R8 no access while invalid", acc_n, 0);
    chk(frm_done == 0, "R8 frame waits while invalid", frm_done, 0);
    frm_valid = 0;
  endtask

  task automatic t_basic;
    int w0;
    desc(12'h100, 16'h8000, 16'h0400, 16'hFFE0);
    for (int i = 0; i < 80; i++) mem[(12'h400 >> 1) + i] = 16'h5A5A;
    fill_frame(70, 3);
    int_en = 1; vec_reg = 16'hFFFF;
    w0 = wn;
    load_list(12'h100);
    chk(list_inv == 0, "R1 load clears invalid", list_inv, 0);
    run_frame(0);
    chk(wn - w0 == 69, "R4 write count 64 bytes", wn - w0, 69);
    chk(la[w0] == 12'h100 && ld[w0] == 16'hFFFF, "R5 busy flag first", ld[w0], 16'hFFFF);
    begin
      bit ok = 1;
      for (int i = 0; i < 64; i++) if (rdb(12'h400 + i) != 8'(i * 7 + 3)) ok = 0;
      chk(ok, "R4 buffer contents", 0, 0);
    end
    chk(rdb(12'h400 + 64) == 8'h5A, "R4 byte past buffer untouched", rdb(12'h440), 8'h5A);
    chk(la[w0 + 65] == 12'h108 && ld[w0 + 65] == 16'h00F8, "R6 status1", ld[w0 + 65], 16'h00F8);
    chk(la[w0 + 66] == 12'h10A && ld[w0 + 66] == 16'h0A0A, "R6 status2", ld[w0 + 66], 16'h0A0A);
    chk(la[w0 + 67] == 12'h100 && ld[w0 + 67] == 16'h0300, "R5 done flag", ld[w0 + 67], 16'h0300);
    chk(la[w0 + 68] == 12'h102 && ld[w0 + 68] == 16'h0000, "R5 addr-high cleared last", ld[w0 + 68], 0);
    chk(rx_int == 1, "R7 rx_int set", rx_int, 1);
    chk(irq_n == 1 && last_vec == 16'h03FC, "R7 irq vector", last_vec, 16'h03FC);
    chk(list_inv == 1, "R8 invalid after frame", list_inv, 1);
    chk(drop_cnt == 0, "R9 no drop", drop_cnt, 0);
  endtask

  task automatic t_chain;
    int w0;
    @(negedge clk); rx_int_clr = 1; @(negedge clk); rx_int_clr = 0;
    chk(rx_int == 0, "R7 clear", rx_int, 0);
    desc(12'h200, 16'hC000, 16'h0300, 16'h0000);
    desc(12'h300, 16'h8000, 16'h0500, 16'hFFF0);
    fill_frame(20, 9);
    int_en = 0;
    w0 = wn;
    load_list(12'h200);
    run_frame(0);
    chk(la[w0] == 12'h300, "R3 jump target used", la[w0], 12'h300);
    chk(mem[12'h200 >> 1] == 16'h1111, "R3 jump descriptor not written", mem[12'h100], 16'h1111);
    chk(rdb(12'h500 + 19) == 8'(19 * 7 + 9), "R4 last byte copied", rdb(12'h513), 8'(19 * 7 + 9));
    chk(mem[12'h308 >> 1] == 16'h00F8 && mem[12'h30A >> 1] == 16'h0000, "R6 short frame status", mem[12'h308 >> 1], 16'h00F8);
    chk(rx_int == 1 && irq_n == 1, "R7 flag without irq when disabled", irq_n, 1);
  endtask

  task automatic t_end_marker;
    int a0;
    desc(12'h600, 16'h0000, 16'h0700, 16'hFFF0);
    fill_frame(30, 2);
    load_list(12'h600);
    a0 = acc_n;
    run_frame(0);
    chk(acc_n - a0 == 3, "R2 three reads then stop", acc_n - a0, 3);
    chk(drop_cnt == 1, "R9 drop on end marker", drop_cnt, 1);
    chk(list_inv == 1, "R8 invalid after drop", list_inv, 1);
  endtask

  task automatic t_bounds;
    int a0;
    fill_frame(30, 4);
    load_list(12'hFF8);
    a0 = acc_n;
    run_frame(0);
    chk(acc_n == a0, "R9 no access past memory", acc_n - a0, 0);
    chk(drop_cnt == 2, "R9 drop past memory", drop_cnt, 2);
  endtask

  task automatic t_collide;
    desc(12'h700, 16'h8000, 16'h0800, 16'hFF00);
    fill_frame(400, 5);
    int_en = 1; vec_reg = 16'h0155;
    load_list(12'h700);
    run_frame(1);
    chk(rx_int == 1, "R7 set wins over clear", rx_int, 1);
    chk(list_inv == 0, "R1 load wins over completion", list_inv, 0);
    chk(mem[12'h708 >> 1] == 16'h01F8, "R6 status1 high bits", mem[12'h708 >> 1], 16'h01F8);
    chk(mem[12'h70A >> 1] == 16'h5454, "R6 status2 mirrored", mem[12'h70A >> 1], 16'h5454);
    chk(last_vec == 16'h0154 && irq_n == 2, "R7 vector mask", last_vec, 16'h0154);
    chk(rdb(12'h800 + 399) == 8'(399 * 7 + 5), "R10 long copy under stalls", rdb(12'h800 + 399), 8'(399 * 7 + 5));
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_chain;
    t_end_marker;
    t_bounds;
    t_collide;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule